// File: doc/BRIEF.md
# Barrel Shifter with Rotate

This block is the shift and rotate unit of a 32-bit integer datapath built around three-register instructions. It is purely combinational. It reads the six-bit function field of the instruction, the five-bit shift-amount field, and the lowest bit of the first source-register field. It also takes the values of both source registers. It returns the shifted or rotated second source value together with a flag that says whether the function code belongs to the shift family.

Six function codes are recognised. They cover logical left shift, logical right shift, arithmetic right shift and rotate right. Each comes in an immediate-amount form, where the amount is taken from the instruction's shift-amount field, and a variable-amount form, where the amount is the low five bits of the first source value. Rotate right has no code of its own. It shares the logical-right code, and a selector bit inside the instruction picks it: instruction bit 21 for the immediate form and instruction bit 6 for the variable form. Pipeline staging, register file access and the special no-operation encodings are handled elsewhere; a no-operation word simply arrives here as a left shift of zero by zero.

The shifter is a logarithmic network with one stage per amount bit. Left shifts reuse the right-shift network by reversing the bit order on the way in and on the way out.

Top module: `shift_rotate_unit`

## Requirements
- R1: Function code 0x00 returns `rt_value` shifted left by `sa_field`, with zeros filling the low bits.
- R2: Function code 0x02 with `rs_field_lsb` = 0 returns `rt_value` shifted right logically by `sa_field`.
- R3: Function code 0x02 with `rs_field_lsb` = 1 returns `rt_value` rotated right by `sa_field`; bits leaving bit 0 re-enter at bit 31.
- R4: Function code 0x03 returns `rt_value` shifted right by `sa_field` with copies of bit 31 filling the top.
- R5: Function code 0x04 returns `rt_value` shifted left by `rs_value[4:0]`; `rs_value[31:5]` has no effect.
- R6: Function code 0x06 returns `rt_value` shifted right logically by `rs_value[4:0]` when `sa_field[0]` = 0, and rotated right by `rs_value[4:0]` when `sa_field[0]` = 1.
- R7: Function code 0x07 returns `rt_value` shifted right arithmetically by `rs_value[4:0]`.
- R8: For every recognised form, an amount of 0 returns `rt_value` unchanged, rotate included.
- R9: For every function code other than 0x00, 0x02, 0x03, 0x04, 0x06 and 0x07, `valid` is 0 and `result` is 0; for those six codes `valid` is 1.
- R10: Inputs not named in a form's definition have no effect on the result. `rs_field_lsb` is ignored by every code except 0x02. `sa_field` and `sa_field[0]` are ignored by the variable forms except as the selector of 0x06. `rs_value` is ignored by the immediate forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| funct | input | 6 | Function field of the instruction (bits 5:0) |
| sa_field | input | 5 | Shift-amount field of the instruction (bits 10:6) |
| rs_field_lsb | input | 1 | Lowest bit of the first source-register field (instruction bit 21) |
| rs_value | input | 32 | Value of the first source register; low five bits give the variable amount |
| rt_value | input | 32 | Value of the second source register; the operand that is shifted |
| result | output | 32 | Shifted or rotated operand, zero when `valid` is low |
| valid | output | 1 | High when the function code is one of the six shift encodings |

## Verification
The bench builds the unit with its default 32-bit width. At that width every function code, every value of the shift-amount field and both values of the register-field selector can be swept in full. For each combination it applies several operand patterns: a sign-set word, a sign-clear word, a mixed word and a random word. The upper bits of the first source value are randomised, so the ignored inputs vary on every vector. A separate pass repeats selected vectors with the ignored fields flipped and requires an identical result.

// File: rtl/shift_rotate_pkg.sv
// Package: shift_rotate_pkg
// Shared encodings for the shift/rotate unit: the kind of operation the
// shifter network performs and the function codes it recognises.
package shift_rotate_pkg;

    // Operation carried out by the shifter network.
    typedef enum logic [1:0] {
        KIND_SHL = 2'd0,   // logical left
        KIND_SHR = 2'd1,   // logical right
        KIND_SAR = 2'd2,   // arithmetic right
        KIND_ROR = 2'd3    // rotate right
    } shift_kind_e;

    // Decoded control for one instruction.
    typedef struct packed {
        logic        known;     // function code is in the shift family
        logic        reg_amt;   // amount comes from a register value
        shift_kind_e kind;      // network operation
    } shift_ctl_t;

    // Function codes of the shift family.
    localparam logic [5:0] FN_SHL_IMM = 6'h00;
    localparam logic [5:0] FN_SHR_IMM = 6'h02;
    localparam logic [5:0] FN_SAR_IMM = 6'h03;
    localparam logic [5:0] FN_SHL_VAR = 6'h04;
    localparam logic [5:0] FN_SHR_VAR = 6'h06;
    localparam logic [5:0] FN_SAR_VAR = 6'h07;

endpackage

// File: rtl/shift_rotate_decode.sv
// Module: shift_rotate_decode
// Turns the function field plus the selector bits into shifter control.
// Assumes the caller has already decided the instruction is a register-format
// word; only the function field and the two selector bits are looked at.
module shift_rotate_decode
    import shift_rotate_pkg::*;
(
    input  logic [5:0]  funct,
    input  logic        imm_sel,   // rotate selector for the immediate form
    input  logic        var_sel,   // rotate selector for the variable form
    output shift_ctl_t  ctl
);

    // Map each function code to its network operation and amount source.
    always_comb begin
        ctl = '{known: 1'b0, reg_amt: 1'b0, kind: KIND_SHL};
        case (funct)
            FN_SHL_IMM: ctl = '{known: 1'b1, reg_amt: 1'b0, kind: KIND_SHL};
            FN_SHR_IMM: ctl = '{known: 1'b1, reg_amt: 1'b0,
                                kind: imm_sel ? KIND_ROR : KIND_SHR};
            FN_SAR_IMM: ctl = '{known: 1'b1, reg_amt: 1'b0, kind: KIND_SAR};
            FN_SHL_VAR: ctl = '{known: 1'b1, reg_amt: 1'b1, kind: KIND_SHL};
            FN_SHR_VAR: ctl = '{known: 1'b1, reg_amt: 1'b1,
                                kind: var_sel ? KIND_ROR : KIND_SHR};
            FN_SAR_VAR: ctl = '{known: 1'b1, reg_amt: 1'b1, kind: KIND_SAR};
            default:    ctl = '{known: 1'b0, reg_amt: 1'b0, kind: KIND_SHL};
        endcase
    end

    // Check that recognised codes all sit in the lowest group of eight.
    always_comb begin
        if (ctl.known) begin
            AST_KNOWN_IN_GROUP: assert (funct[5:3] == 3'b000)
                else $error("decoder accepted code outside shift group"); // R9
        end
    end

endmodule

// File: rtl/shift_rotate_amount.sv
// Module: shift_rotate_amount
// Selects the shift distance: the instruction field for immediate forms or
// the low bits of the register value for variable forms.
module shift_rotate_amount #(
    parameter int AMT_W = 5
) (
    input  logic [AMT_W-1:0] imm_amt,
    input  logic [AMT_W-1:0] reg_amt_bits,
    input  logic             use_reg,
    output logic [AMT_W-1:0] amt
);

    // Two-way select of the amount source.
    always_comb begin
        amt = use_reg ? reg_amt_bits : imm_amt;
    end

endmodule

// File: rtl/shift_rotate_core.sv
// Module: shift_rotate_core
// Logarithmic right-shift network with a fill/rotate choice per stage.
// Left shifts reuse the same network by reversing the operand bit order on
// the way in and on the way out. Assumes WIDTH is a power of two.
module shift_rotate_core
    import shift_rotate_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] amt,
    input  shift_kind_e      kind,
    output logic [WIDTH-1:0] data_out
);

    logic             is_left;
    logic             is_rot;
    logic             fill_bit;
    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] net_in;
    logic [WIDTH-1:0] net_out;
    logic [WIDTH-1:0] rev_out;
    logic [WIDTH-1:0] stage [0:AMT_W];

    // Derive the per-operation controls of the network.
    always_comb begin
        is_left  = (kind == KIND_SHL);
        is_rot   = (kind == KIND_ROR);
        fill_bit = (kind == KIND_SAR) ? data_in[WIDTH-1] : 1'b0;
    end

    // Bit reversal of the operand and of the network output.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign rev_in[i]  = data_in[WIDTH-1-i];
        assign rev_out[i] = net_out[WIDTH-1-i];
    end

    // Feed the network with the reversed operand for left shifts.
    always_comb begin
        net_in = is_left ? rev_in : data_in;
    end

    assign stage[0] = net_in;

    // One stage per amount bit; stage k moves by 2**k when amt[k] is set.
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int DIST = 1 << k;
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic src;
            if (i + DIST < WIDTH) begin : g_inside
                assign src = stage[k][i+DIST];
            end else begin : g_edge
                assign src = is_rot ? stage[k][i+DIST-WIDTH] : fill_bit;
            end
            assign stage[k+1][i] = amt[k] ? src : stage[k][i];
        end
    end

    assign net_out = stage[AMT_W];

    // Undo the reversal for left shifts.
    always_comb begin
        data_out = is_left ? rev_out : net_out;
    end

    // Logical shifts can only drop ones, never create them.
    always_comb begin
        if (kind == KIND_SHL || kind == KIND_SHR) begin
            AST_SHIFT_NO_NEW_ONES: assert ($countones(data_out) <= $countones(data_in))
                else $error("logical shift created ones"); // R1
        end
    end

endmodule

// File: rtl/shift_rotate_unit.sv
// Module: shift_rotate_unit
// Top of the combinational shift/rotate unit. Decodes the function field,
// picks the amount source, runs the shifter network and gates the result
// with the recognition flag. Assumes the instruction is register-format.
module shift_rotate_unit
    import shift_rotate_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [5:0]       funct,
    input  logic [AMT_W-1:0] sa_field,
    input  logic             rs_field_lsb,
    input  logic [WIDTH-1:0] rs_value,
    input  logic [WIDTH-1:0] rt_value,
    output logic [WIDTH-1:0] result,
    output logic             valid
);

    shift_ctl_t       ctl;
    logic [AMT_W-1:0] amt;
    logic [WIDTH-1:0] shifted;
    logic             unused_rs_hi;

    // Upper register bits play no part in the amount.
    assign unused_rs_hi = ^rs_value[WIDTH-1:AMT_W];

    shift_rotate_decode u_decode (
        .funct   (funct),
        .imm_sel (rs_field_lsb),
        .var_sel (sa_field[0]),
        .ctl     (ctl)
    );

    shift_rotate_amount #(.AMT_W(AMT_W)) u_amount (
        .imm_amt      (sa_field),
        .reg_amt_bits (rs_value[AMT_W-1:0]),
        .use_reg      (ctl.reg_amt),
        .amt          (amt)
    );

    shift_rotate_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_core (
        .data_in  (rt_value),
        .amt      (amt),
        .kind     (ctl.kind),
        .data_out (shifted)
    );

    // Gate the network output with the recognition flag.
    always_comb begin
        valid  = ctl.known;
        result = ctl.known ? shifted : '0;
    end

    // Output-level properties across the submodules.
    always_comb begin
        if (!valid) begin
            AST_UNKNOWN_ZERO: assert (result == '0)
                else $error("unrecognised code produced data"); // R9
        end
        if (valid && amt == '0) begin
            AST_ZERO_AMOUNT_PASS: assert (result == rt_value)
                else $error("zero amount altered operand"); // R8
        end
        if (valid && ctl.kind == KIND_ROR) begin
            AST_ROTATE_KEEPS_ONES: assert ($countones(result) == $countones(rt_value))
                else $error("rotate changed population"); // R3
        end
        if (valid && ctl.kind == KIND_SAR) begin
            AST_ARITH_SIGN_KEPT: assert (result[WIDTH-1] == rt_value[WIDTH-1])
                else $error("arithmetic shift lost sign"); // R4
        end
    end

endmodule

// File: tb/shift_rotate_unit_test.sv
`timescale 1ns/1ps
module shift_rotate_unit_test;

    logic        clk = 1'b0;
    logic [5:0]  funct;
    logic [4:0]  sa_field;
    logic        rs_field_lsb;
    logic [31:0] rs_value;
    logic [31:0] rt_value;
    logic [31:0] result;
    logic        valid;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    shift_rotate_unit uut (
        .funct        (funct),
        .sa_field     (sa_field),
        .rs_field_lsb (rs_field_lsb),
        .rs_value     (rs_value),
        .rt_value     (rt_value),
        .result       (result),
        .valid        (valid)
    );

    // Arithmetic reference built from the requirements.
    function automatic void model(input logic [5:0] f, input logic [4:0] sa,
                                  input logic r21, input logic [31:0] rs,
                                  input logic [31:0] rt,
                                  output logic v, output logic [31:0] res);
        logic [4:0]  n;
        logic        rot;
        logic [63:0] dbl;
        n   = f[2] ? rs[4:0] : sa;
        rot = f[2] ? sa[0] : r21;
        dbl = {rt, rt} >> n;
        v   = 1'b1;
        case (f)
            6'h00, 6'h04: res = rt << n;
            6'h02, 6'h06: res = rot ? dbl[31:0] : (rt >> n);
            6'h03, 6'h07: res = 32'($signed(rt) >>> n);
            default: begin v = 1'b0; res = 32'h0; end
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] f, input logic [4:0] sa,
                                     input logic r21, input logic [31:0] rs);
        logic [4:0] n;
        n = f[2] ? rs[4:0] : sa;
        case (f)
            6'h00:   return (n == 0) ? "R8" : (r21 ? "R10" : "R1");
            6'h02:   return (n == 0) ? "R8" : (r21 ? "R3" : "R2");
            6'h03:   return (n == 0) ? "R8" : "R4";
            6'h04:   return (n == 0) ? "R8" : "R5";
            6'h06:   return (n == 0) ? "R8" : "R6";
            6'h07:   return (n == 0) ? "R8" : "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [31:0] exp_res,
                           input logic exp_v);
        checks++;
        if (result !== exp_res || valid !== exp_v) begin
            failures++;
            $display("FAIL %s funct=%h sa=%0d r21=%b rs=%h rt=%h : got %h/%b expected %h/%b",
                     tag, funct, sa_field, rs_field_lsb, rs_value, rt_value,
                     result, valid, exp_res, exp_v);
        end
    endtask

    task automatic apply(input logic [5:0] f, input logic [4:0] sa,
                         input logic r21, input logic [31:0] rs,
                         input logic [31:0] rt);
        @(posedge clk);
        funct = f; sa_field = sa; rs_field_lsb = r21; rs_value = rs; rt_value = rt;
        @(negedge clk);
    endtask

    function automatic logic [31:0] pattern(input int p);
        case (p)
            0:       return 32'hF0E1_D2C3;
            1:       return 32'h8000_0000;
            2:       return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    // Watchdog: a hung run is reported as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

    initial begin
        logic        ev;
        logic [31:0] er;
        logic [31:0] first;
        funct = '0; sa_field = '0; rs_field_lsb = 1'b0; rs_value = '0; rt_value = '0;

        // Idle state: a zero word is a left shift of zero by zero (R1, R8).
        @(negedge clk);
        compare("R8", 32'h0, 1'b1);

        // Exhaustive sweep of code, amount field and selector.
        for (int f = 0; f < 64; f++) begin
            for (int s = 0; s < 32; s++) begin
                for (int b = 0; b < 2; b++) begin
                    for (int p = 0; p < 4; p++) begin
                        logic [31:0] rs;
                        logic [31:0] rt;
                        rt = pattern(p);
                        rs = {$urandom % (1 << 27), 5'(s * 7 + p)};
                        apply(6'(f), 5'(s), b[0], rs, rt);
                        model(6'(f), 5'(s), b[0], rs, rt, ev, er);
                        compare(tag_of(6'(f), 5'(s), b[0], rs), er, ev);
                    end
                end
            end
        end

        // R10: flipping ignored fields leaves the result unchanged.
        for (int f = 0; f < 8; f++) begin
            for (int n = 0; n < 32; n += 5) begin
                logic [31:0] rt;
                rt = $urandom;
                // Immediate forms: vary rs_value; selector ignored for 0x00/0x03.
                if (f == 0 || f == 3) begin
                    apply(6'(f), 5'(n), 1'b0, 32'h0, rt);
                    first = result;
                    apply(6'(f), 5'(n), 1'b1, $urandom, rt);
                    compare("R10", first, 1'b1);
                end
                if (f == 2) begin
                    apply(6'(f), 5'(n), 1'b1, 32'h0, rt);
                    first = result;
                    apply(6'(f), 5'(n), 1'b1, $urandom, rt);
                    compare("R10", first, 1'b1);
                end
                // Variable forms: vary sa[4:1], rs field bit and rs upper bits.
                if (f >= 4 && f != 5) begin
                    apply(6'(f), 5'b00000, 1'b0, 32'(n), rt);
                    first = result;
                    apply(6'(f), 5'b11110, 1'b1, {27'h5A5A5A5, 5'(n)}, rt);
                    compare("R10", first, 1'b1);
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

endmodule